// File: doc/BRIEF.md
# Serial Crosspoint Program and Scan Port

This block is the serial front end of a crosspoint switch's program memory. It has two jobs. The first is to take routing commands from a one-bit serial line. The second is to read the entire selection memory back over the same line.

In command mode, every rising edge of the shift clock moves one bit into a word register. The word register has two fields. The first field shifted in is the output number and the second is the input number. The caller raises the word-load strobe on the edge that carries the final bit. That edge issues a one-cycle write, on the shadow-write port, to the named output. The serial output repeats the serial input fourteen enabled edges later. Several devices can therefore be chained so that one shared word-load strobe programs all of them at once.

For read-back, one enabled edge with scan mode low takes a parallel snapshot of every main-latch selection into a long scan register. After that, each edge with scan mode high moves the snapshot out on the serial output. The highest slice comes out first, and each word is sent most significant bit first. When the port enable is low, the clock has no effect.

Top module: `xpSerialPort`

## Requirements
- R1: While `rstN` is low, the word register and the scan register are cleared, `shiftOut` is 0, and `shadowWe` and `shadowOff` are 0.
- R2: In command mode (`portEnable`=1, `scanMode`=0), `shiftOut` equals the `shiftIn` value that was sampled 14 enabled command-mode edges earlier. The output shows 0 until 14 bits have entered.
- R3: An enabled command-mode edge with `wordLoad`=1 forms a 14-bit word. The word is the 13 earlier bits plus the current bit. The first 7 bits shifted in are the output number and the last 7 are the input number, each MSB first. For the following cycle, `shadowWe`=1, `shadowAddr` holds the output number and `shadowData` holds the input number.
- R4: A word whose output number is 37 or above produces no write: `shadowWe` stays 0.
- R5: `shadowOff` is 1, together with `shadowWe`, exactly when a write carries the input number 127 (all ones). Otherwise `shadowOff` is 0.
- R6: Each enabled edge with `scanMode`=0 loads the scan register from `latchFlat`. Slice s is read from bits [6s+5:6s]. While `scanMode`=1, `shiftOut` presents the scan register, and each enabled edge advances it by one bit. The order is slice 36 down to slice 0, each word MSB first, followed by 0s.
- R7: Each 6-bit latch value is widened to a 7-bit word with a leading 0. The first bit of every scanned word is therefore 0.
- R8: With `portEnable`=0, an edge changes nothing. `shiftOut` keeps its value, `wordLoad` is ignored, and `shadowWe` is 0 on the next cycle.
- R9: While `scanMode`=1, the word register holds its contents and `wordLoad` is ignored. When the port returns to command mode, the delayed stream resumes where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial shift clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| portEnable | input | 1 | Serial mode enable; when low the clock is ignored |
| scanMode | input | 1 | 1 = shift the scan register out, 0 = command mode with capture |
| wordLoad | input | 1 | Asserted with the last bit of a command word |
| shiftIn | input | 1 | Serial data in |
| latchFlat | input | 222 | Main-latch selections, 37 slices of 6 bits, slice 0 in the low bits |
| shiftOut | output | 1 | Delayed data in command mode, scan data in scan mode |
| shadowWe | output | 1 | One-cycle shadow-register write strobe |
| shadowAddr | output | 7 | Output number being written |
| shadowData | output | 7 | Input number to route to that output |
| shadowOff | output | 1 | Write carries the disable code |

## Verification
The command path is driven three ways. A pseudo-random bit stream with no load strobe exposes any error in the 14-edge delay. Framed words with valid, boundary (36), out-of-range (37, 100) and all-ones fields separate field ordering, address filtering and disable decoding. Back-to-back words check that framing depends only on the strobe. Read-back uses a latch pattern that differs in every slice, so a wrong slice order, bit order or zero extension gives a distinct mismatch. Disabled cycles and strobes issued during scanning are interleaved to show that neither path disturbs the other's state.

// File: rtl/xpPkg.sv
package xpPkg;
  typedef struct packed {
    logic shiftCmd;
    logic capture;
    logic shiftScan;
    logic writeCmd;
  } xpStrobeT;
endpackage

// File: rtl/xpScanCtrl.sv
module xpScanCtrl
  import xpPkg::*;
(
  input  logic     portEnable,
  input  logic     scanMode,
  input  logic     wordLoad,
  output xpStrobeT strobes
);
  always_comb begin
    strobes = '0;
    if (portEnable) begin
      if (scanMode) begin
        strobes.shiftScan = 1'b1;
      end else begin
        strobes.shiftCmd = 1'b1;
        strobes.capture  = 1'b1;
        strobes.writeCmd = wordLoad;
      end
    end
  end
endmodule

// File: rtl/xpScanDatapath.sv
module xpScanDatapath
  import xpPkg::*;
#(
  parameter int NUM_SLICES = 37,
  parameter int FIELD_W    = 7,
  parameter int LATCH_W    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  xpStrobeT                      strobes,
  input  logic                          scanMode,
  input  logic                          shiftIn,
  input  logic [NUM_SLICES*LATCH_W-1:0] latchFlat,
  output logic                          shiftOut,
  output logic                          shadowWe,
  output logic [FIELD_W-1:0]            shadowAddr,
  output logic [FIELD_W-1:0]            shadowData,
  output logic                          shadowOff
);
  localparam int WORD_W = 2 * FIELD_W;
  localparam int SCAN_W = NUM_SLICES * FIELD_W;
  localparam logic [FIELD_W-1:0] OFF_CODE = '1;
  localparam logic [FIELD_W-1:0] ADDR_LIMIT = FIELD_W'(NUM_SLICES);

  logic [WORD_W-1:0]  cmdSr;
  logic [WORD_W-1:0]  nextWord;
  logic [FIELD_W-1:0] addrField;
  logic [FIELD_W-1:0] dataField;
  logic               addrValid;
  logic [SCAN_W-1:0]  scanSr;
  logic [SCAN_W-1:0]  capImg;

  assign nextWord  = {cmdSr[WORD_W-2:0], shiftIn};
  assign addrField = nextWord[WORD_W-1:FIELD_W];
  assign dataField = nextWord[FIELD_W-1:0];
  assign addrValid = addrField < ADDR_LIMIT;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : gSlice
    if (FIELD_W > LATCH_W) begin : gPad
      assign capImg[s*FIELD_W +: FIELD_W] =
        {{(FIELD_W-LATCH_W){1'b0}}, latchFlat[s*LATCH_W +: LATCH_W]};
    end else begin : gNoPad
      assign capImg[s*FIELD_W +: FIELD_W] = latchFlat[s*LATCH_W +: FIELD_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdSr <= '0;
    end else if (strobes.shiftCmd) begin
      cmdSr <= nextWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanSr <= '0;
    end else if (strobes.capture) begin
      scanSr <= capImg;
    end else if (strobes.shiftScan) begin
      scanSr <= {scanSr[SCAN_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowWe   <= 1'b0;
      shadowOff  <= 1'b0;
      shadowAddr <= '0;
      shadowData <= '0;
    end else begin
      shadowWe  <= strobes.writeCmd && addrValid;
      shadowOff <= strobes.writeCmd && addrValid && (dataField == OFF_CODE);
      if (strobes.writeCmd && addrValid) begin
        shadowAddr <= addrField;
        shadowData <= dataField;
      end
    end
  end

  assign shiftOut = scanMode ? scanSr[SCAN_W-1] : cmdSr[WORD_W-1];
endmodule

// File: rtl/xpSerialPort.sv
module xpSerialPort
  import xpPkg::*;
#(
  parameter int NUM_SLICES = 37,
  parameter int FIELD_W    = 7,
  parameter int LATCH_W    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          portEnable,
  input  logic                          scanMode,
  input  logic                          wordLoad,
  input  logic                          shiftIn,
  input  logic [NUM_SLICES*LATCH_W-1:0] latchFlat,
  output logic                          shiftOut,
  output logic                          shadowWe,
  output logic [FIELD_W-1:0]            shadowAddr,
  output logic [FIELD_W-1:0]            shadowData,
  output logic                          shadowOff
);
  xpStrobeT strobes;

  xpScanCtrl uCtrl (
    .portEnable (portEnable),
    .scanMode   (scanMode),
    .wordLoad   (wordLoad),
    .strobes    (strobes)
  );

  xpScanDatapath #(
    .NUM_SLICES (NUM_SLICES),
    .FIELD_W    (FIELD_W),
    .LATCH_W    (LATCH_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .scanMode   (scanMode),
    .shiftIn    (shiftIn),
    .latchFlat  (latchFlat),
    .shiftOut   (shiftOut),
    .shadowWe   (shadowWe),
    .shadowAddr (shadowAddr),
    .shadowData (shadowData),
    .shadowOff  (shadowOff)
  );
endmodule

// File: rtl/xpSerialPortChk.sv
module xpSerialPortChk #(
  parameter int NUM_SLICES = 37,
  parameter int FIELD_W    = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               portEnable,
  input logic               scanMode,
  input logic               wordLoad,
  input logic               shadowWe,
  input logic [FIELD_W-1:0] shadowAddr,
  input logic               shadowOff
);
  localparam logic [FIELD_W-1:0] ADDR_LIMIT = FIELD_W'(NUM_SLICES);

  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r1: assert (!shadowWe && !shadowOff)
        else $error("write port active in reset");
    end
  end

  p_write_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    shadowWe |-> $past(wordLoad && portEnable && !scanMode))
    else $error("write without load strobe");

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    shadowWe |-> (shadowAddr < ADDR_LIMIT))
    else $error("write to nonexistent output");

  p_off_with_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    shadowOff |-> shadowWe)
    else $error("disable flag without write");

  p_idle_no_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    !portEnable |=> !shadowWe)
    else $error("write while disabled");

  p_scan_no_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && scanMode) |=> !shadowWe)
    else $error("write during scan");
endmodule

bind xpSerialPort xpSerialPortChk #(
  .NUM_SLICES (NUM_SLICES),
  .FIELD_W    (FIELD_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .portEnable (portEnable),
  .scanMode   (scanMode),
  .wordLoad   (wordLoad),
  .shadowWe   (shadowWe),
  .shadowAddr (shadowAddr),
  .shadowOff  (shadowOff)
);

// File: tb/sim_xpSerialPort.sv
module sim_xpSerialPort;
  localparam int NS = 37;
  localparam int FW = 7;
  localparam int LW = 6;
  localparam int SW = NS * FW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEnable = 1'b0;
  logic scanMode = 1'b0;
  logic wordLoad = 1'b0;
  logic shiftIn = 1'b0;
  logic [NS*LW-1:0] latchFlat;
  logic shiftOut, shadowWe, shadowOff;
  logic [FW-1:0] shadowAddr, shadowData;
  logic [LW-1:0] latchVal [NS];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  bit cmdHist[$];
  bit scanQ[$];
  bit expWe, expOff;
  int expAddr, expData;

  always #5 clk = ~clk;

  always_comb begin
    for (int s = 0; s < NS; s++) latchFlat[s*LW +: LW] = latchVal[s];
  end

  xpSerialPort u0 (
    .clk(clk), .rstN(rstN), .portEnable(portEnable), .scanMode(scanMode),
    .wordLoad(wordLoad), .shiftIn(shiftIn), .latchFlat(latchFlat),
    .shiftOut(shiftOut), .shadowWe(shadowWe), .shadowAddr(shadowAddr),
    .shadowData(shadowData), .shadowOff(shadowOff)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    bit eo;
    eo = scanMode ? scanQ[0] : cmdHist[0];
    chk(tag, "shiftOut", int'(shiftOut), int'(eo));
    chk(tag, "shadowWe", int'(shadowWe), int'(expWe));
    chk(tag, "shadowOff", int'(shadowOff), int'(expOff));
    if (expWe) begin
      chk(tag, "shadowAddr", int'(shadowAddr), expAddr);
      chk(tag, "shadowData", int'(shadowData), expData);
    end
  endtask

  task automatic modelEdge(input bit en, input bit sc, input bit ld, input bit din);
    expWe = 0;
    expOff = 0;
    if (!en) return;
    if (sc) begin
      void'(scanQ.pop_front());
      scanQ.push_back(1'b0);
      return;
    end
    cmdHist.push_back(din);
    void'(cmdHist.pop_front());
    if (ld) begin
      int a, d;
      a = 0;
      d = 0;
      for (int i = 0; i < FW; i++) begin
        a = a * 2 + int'(cmdHist[i]);
        d = d * 2 + int'(cmdHist[FW + i]);
      end
      if (a < NS) begin
        expWe = 1;
        expAddr = a;
        expData = d;
        expOff = (d == 127);
      end
    end
    scanQ.delete();
    for (int s = NS - 1; s >= 0; s--) begin
      scanQ.push_back(1'b0);
      for (int b = LW - 1; b >= 0; b--) scanQ.push_back(latchVal[s][b]);
    end
  endtask

  task automatic step(input bit en, input bit sc, input bit ld, input bit din, input string tag);
    portEnable = en;
    scanMode = sc;
    wordLoad = ld;
    shiftIn = din;
    @(posedge clk);
    modelEdge(en, sc, ld, din);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic sendWord(input int addr, input int data, input bit ld, input string tag);
    logic [13:0] w;
    w = {addr[6:0], data[6:0]};
    for (int i = 13; i >= 0; i--) step(1, 0, ld && (i == 0), w[i], tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < NS; s++) latchVal[s] = LW'((s * 23 + 5) % 64);
    for (int i = 0; i < 14; i++) cmdHist.push_back(1'b0);
    for (int i = 0; i < SW; i++) scanQ.push_back(1'b0);
    expWe = 0; expOff = 0; expAddr = 0; expData = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    compare("R1");
    rstN = 1'b1;

    // R2: pseudo-random stream, no load
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      step(1, 0, 0, lfsr[0], "R2");
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    // R3: valid writes, boundary output 36
    sendWord(5, 12, 1, "R3");
    step(1, 0, 0, 0, "R3");
    sendWord(36, 0, 1, "R3");
    sendWord(0, 36, 1, "R3");
    step(1, 0, 0, 1, "R3");

    // R4: out-of-range output numbers
    sendWord(37, 3, 1, "R4");
    sendWord(100, 9, 1, "R4");
    step(1, 0, 0, 0, "R4");

    // R5: disable code
    sendWord(17, 127, 1, "R5");
    sendWord(17, 126, 1, "R5");
    step(1, 0, 0, 0, "R5");

    // R8: disabled port ignores everything
    sendWord(9, 1, 0, "R8");
    for (int i = 0; i < 10; i++) step(0, 0, 1, i[0], "R8");
    step(1, 0, 0, 1, "R8");

    // R6 R7: capture then scan out every slice
    step(1, 0, 0, 0, "R6");
    portEnable = 1; scanMode = 1;
    #1 compare("R6 R7");
    for (int i = 0; i < SW + 4; i++) step(1, 1, 0, 0, "R6 R7");

    // R9: strobes during scan ignored, stream resumes
    sendWord(3, 4, 0, "R9");
    step(1, 0, 0, 1, "R9");
    for (int i = 0; i < 5; i++) step(1, 1, 1, i[0], "R9");
    for (int i = 0; i < 20; i++) step(1, 0, 0, i[1], "R9");
    sendWord(8, 127, 1, "R9");
    step(1, 0, 0, 0, "R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule